// File: doc/BRIEF.md
# Multi-mode effective address generator

This block produces the effective address of a memory operand for a small processor core. It also produces the new pointer-register value that auto-modifying addressing modes need. Each cycle, the core presents these inputs:

- a two-bit addressing mode;
- the pointer register value;
- an index register value;
- a segment base;
- an operand size code;
- a scale code;
- a signed displacement.

One clock later the block returns the address. It also returns a write-back value with an enable for the register file.

There are four modes. The plain indirect mode uses the pointer as the address. Post-increment uses the pointer and then bumps it by the operand size. Pre-decrement lowers the pointer by the operand size first and uses the lowered value. The scaled-index mode sums the segment base, the index shifted left by the scale code, the pointer acting as base register, and the sign-extended displacement into one linear address.

All arithmetic wraps modulo 2^AW. Memory access, the register file itself and protection checks are outside this block.

Top module: `eff_addr_gen`

## Requirements
- R1: While `rst_n` is low, and on the first clock edges after it rises with no request, `ea_vld` and `upd_en` are 0.
- R2: Mode code 00 (register indirect) returns `ea` equal to `reg_ptr` with `upd_en` 0.
- R3: Mode code 01 (post-increment) returns `ea` equal to `reg_ptr`, with `upd_en` 1 and `upd_val` equal to `reg_ptr` plus the operand step; `upd_en` is never 1 without `ea_vld`.
- R4: Mode code 10 (pre-decrement) returns `upd_val` equal to `reg_ptr` minus the operand step, with `upd_en` 1 and `ea` equal to that same lowered value.
- R5: The operand step in bytes is 2 raised to `opnd_size`: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8.
- R6: Mode code 11 (scaled index) returns `ea` = `seg_base` + (`reg_idx` << `scale_sel`) + `reg_ptr` + displacement, with `upd_en` 0.
- R7: The scale code selects a left shift of the index by 0, 1, 2 or 3 bits, which is a multiply by 1, 2, 4 or 8.
- R8: Every sum and difference is taken modulo 2^AW, with no overflow indication; a pre-decrement of 0 or an increment past all-ones wraps.
- R9: A result appears exactly one cycle after `req_vld` is sampled high. A cycle with `req_vld` low yields `ea_vld` 0 and `upd_en` 0 on the next cycle. Back-to-back requests give back-to-back results in order.
- R10: `disp` is a DISP_W-bit two's complement value and is sign-extended to AW bits before it is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe: the address inputs are valid this cycle |
| req_mode | input | 2 | Mode: 00 indirect, 01 post-increment, 10 pre-decrement, 11 scaled index |
| reg_ptr | input | AW | Pointer / base register value |
| reg_idx | input | AW | Index register value (scaled mode only) |
| seg_base | input | AW | Segment base (scaled mode only) |
| opnd_size | input | 2 | Operand size code, step = 2^code bytes |
| scale_sel | input | 2 | Index shift amount, 0 to 3 |
| disp | input | DISP_W | Signed displacement (scaled mode only) |
| ea_vld | output | 1 | Result valid |
| ea | output | AW | Effective / linear address |
| upd_en | output | 1 | Pointer register write-back enable |
| upd_val | output | AW | Value to write back to the pointer register |

## Verification
The bench targets the wrap points of the pointer arithmetic. It pre-decrements from zero by eight bytes and post-increments from all-ones by four. A design that saturated, or carried into a flag, would return 0 instead of FFFFFFF8, or would hold the pointer instead of wrapping it to 3.

Pre-decrement is checked for using the lowered pointer as the address. A design that swapped the pre and post ordering would show the old pointer on `ea` while `upd_val` differs.

Every size code and every scale code is swept, so a decoder that is off by one step shows up as a factor-of-two error. Negative displacements catch a zero-extended offset, which would land 64 KiB too high.

Back-to-back requests in mixed modes, with idle gaps between them, check that results stay in order. They also check that no write-back leaks out of the indirect or scaled modes.

// File: rtl/eag_pkg.sv
package eag_pkg;

   typedef enum logic [1:0] {
      AM_IND    = 2'b00,
      AM_POST   = 2'b01,
      AM_PREDEC = 2'b10,
      AM_SCALED = 2'b11
   } am_mode_e;

endpackage

// File: rtl/eag_step.sv
// Operand-size decoder: size code k -> step of 2^k bytes.
module eag_step #(
   parameter int AW            = 32,
   parameter int SIZE_W        = 2,
   parameter bit STEP_BY_SHIFT = 1'b1
) (
   input  logic [SIZE_W-1:0] size_code,
   output logic [AW-1:0]     step
);
   localparam int NSIZES = 1 << SIZE_W;

   if (NSIZES > AW) begin : g_bad_size
      $error("eag_step: SIZE_W too wide for AW");
   end

   if (STEP_BY_SHIFT) begin : g_shift
      always_comb step = AW'(1) << size_code;
   end else begin : g_decode
      always_comb begin
         step = '0;
         for (int k = 0; k < NSIZES; k++) begin
            if (size_code == SIZE_W'(k)) step[k] = 1'b1;
         end
      end
   end

   // R5
   always_comb begin
      if (!$isunknown(size_code)) begin
         step_onehot_chk: assert ($countones(step) == 1);
      end
   end

endmodule

// File: rtl/eag_index.sv
// Index scaler: left shift by scale code.
module eag_index #(
   parameter int AW           = 32,
   parameter int SCALE_W      = 2,
   parameter bit SCALE_BY_MUX = 1'b0
) (
   input  logic [AW-1:0]      idx,
   input  logic [SCALE_W-1:0] sel,
   output logic [AW-1:0]      scaled
);
   localparam int NSCALES = 1 << SCALE_W;

   if (NSCALES > AW) begin : g_bad_scale
      $error("eag_index: SCALE_W too wide for AW");
   end

   if (SCALE_BY_MUX) begin : g_mux
      always_comb begin
         scaled = idx;
         for (int k = 0; k < NSCALES; k++) begin
            if (sel == SCALE_W'(k)) scaled = idx << k;
         end
      end
   end else begin : g_barrel
      always_comb scaled = idx << sel;
   end

   // R7
   always_comb begin
      if (!$isunknown(sel) && !$isunknown(idx) && sel == '0) begin
         scale_unity_chk: assert (scaled == idx);
      end
   end

endmodule

// File: rtl/eag_sum.sv
// Four-operand linear address adder, modulo 2^AW.
module eag_sum #(
   parameter int AW       = 32,
   parameter int DISP_W   = 16,
   parameter bit SUM_TREE = 1'b1
) (
   input  logic [AW-1:0]     seg,
   input  logic [AW-1:0]     scaled_idx,
   input  logic [AW-1:0]     base,
   input  logic [DISP_W-1:0] disp,
   output logic [AW-1:0]     lin
);
   if (DISP_W > AW || DISP_W < 1) begin : g_bad_disp
      $error("eag_sum: DISP_W must lie in 1..AW");
   end

   logic signed [DISP_W-1:0] disp_s;
   logic        [AW-1:0]     disp_ext;

   always_comb begin
      disp_s   = disp;
      disp_ext = AW'(disp_s);
   end

   if (SUM_TREE) begin : g_tree
      logic [AW-1:0] left_sum, right_sum;
      always_comb begin
         left_sum  = seg + scaled_idx;
         right_sum = base + disp_ext;
         lin       = left_sum + right_sum;
      end
   end else begin : g_chain
      always_comb lin = ((seg + scaled_idx) + base) + disp_ext;
   end

   // R10
   always_comb begin
      if (!$isunknown(disp)) begin
         disp_sign_chk: assert (disp_ext[AW-1] == disp[DISP_W-1]);
      end
   end

endmodule

// File: rtl/eag_ptr.sv
// Pointer step unit: incremented and decremented candidates.
module eag_ptr #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] ptr,
   input  logic [AW-1:0] step,
   output logic [AW-1:0] ptr_inc,
   output logic [AW-1:0] ptr_dec
);
   always_comb begin
      ptr_inc = ptr + step;
      ptr_dec = ptr - step;
   end

   // R8
   always_comb begin
      if (!$isunknown(ptr) && !$isunknown(step)) begin
         inc_dec_pair_chk: assert (ptr_inc - ptr_dec == (step << 1));
      end
   end

endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
   import eag_pkg::*;
#(
   parameter int AW            = 32,
   parameter int DISP_W        = 16,
   parameter int SIZE_W        = 2,
   parameter int SCALE_W       = 2,
   parameter bit STEP_BY_SHIFT = 1'b1,
   parameter bit SCALE_BY_MUX  = 1'b0,
   parameter bit SUM_TREE      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   input  logic [1:0]        req_mode,
   input  logic [AW-1:0]     reg_ptr,
   input  logic [AW-1:0]     reg_idx,
   input  logic [AW-1:0]     seg_base,
   input  logic [SIZE_W-1:0] opnd_size,
   input  logic [SCALE_W-1:0] scale_sel,
   input  logic [DISP_W-1:0] disp,
   output logic              ea_vld,
   output logic [AW-1:0]     ea,
   output logic              upd_en,
   output logic [AW-1:0]     upd_val
);
   if (AW < 8) begin : g_bad_aw
      $error("eff_addr_gen: AW must be at least 8");
   end

   am_mode_e      mode;
   logic [AW-1:0] step_w, scaled_w, lin_w, inc_w, dec_w;
   logic [AW-1:0] ea_n, val_n;
   logic          wb_n;
   logic          vld_q, wb_q;
   logic [AW-1:0] ea_q, val_q;

   assign mode = am_mode_e'(req_mode);

   eag_step #(.AW(AW), .SIZE_W(SIZE_W), .STEP_BY_SHIFT(STEP_BY_SHIFT)) u_step (
      .size_code (opnd_size),
      .step      (step_w)
   );

   eag_index #(.AW(AW), .SCALE_W(SCALE_W), .SCALE_BY_MUX(SCALE_BY_MUX)) u_index (
      .idx    (reg_idx),
      .sel    (scale_sel),
      .scaled (scaled_w)
   );

   eag_sum #(.AW(AW), .DISP_W(DISP_W), .SUM_TREE(SUM_TREE)) u_sum (
      .seg        (seg_base),
      .scaled_idx (scaled_w),
      .base       (reg_ptr),
      .disp       (disp),
      .lin        (lin_w)
   );

   eag_ptr #(.AW(AW)) u_ptr (
      .ptr     (reg_ptr),
      .step    (step_w),
      .ptr_inc (inc_w),
      .ptr_dec (dec_w)
   );

   always_comb begin
      ea_n  = reg_ptr;
      val_n = reg_ptr;
      wb_n  = 1'b0;
      unique case (mode)
         AM_IND: begin
            ea_n = reg_ptr;
         end
         AM_POST: begin
            ea_n  = reg_ptr;
            val_n = inc_w;
            wb_n  = 1'b1;
         end
         AM_PREDEC: begin
            ea_n  = dec_w;
            val_n = dec_w;
            wb_n  = 1'b1;
         end
         AM_SCALED: begin
            ea_n = lin_w;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         wb_q  <= 1'b0;
         ea_q  <= '0;
         val_q <= '0;
      end else begin
         vld_q <= req_vld;
         if (req_vld) begin
            wb_q  <= wb_n;
            ea_q  <= ea_n;
            val_q <= val_n;
         end
      end
   end

   assign ea_vld  = vld_q;
   assign ea      = ea_q;
   assign upd_en  = vld_q & wb_q;
   assign upd_val = val_q;

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> !ea_vld && !upd_en);

   // R3
   wb_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |-> ea_vld);

   // R3
   post_inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld && req_mode == 2'b01 |=>
         upd_en && ea == $past(reg_ptr) && upd_val == ea + $past(step_w));

   // R4
   pre_dec_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld && req_mode == 2'b10 |=>
         upd_en && upd_val == ea && ea + $past(step_w) == $past(reg_ptr));

   // R2
   no_wb_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld && (req_mode == 2'b00 || req_mode == 2'b11) |=> ea_vld && !upd_en);

   // R9
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> ea_vld);

   // R9
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> !ea_vld && !upd_en);

endmodule

// File: tb/eff_addr_gen_tb.sv
`timescale 1ns/1ps
module eff_addr_gen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 1'b0;
   logic [1:0]  req_mode = 2'b00;
   logic [31:0] reg_ptr = '0, reg_idx = '0, seg_base = '0;
   logic [1:0]  opnd_size = 2'b00, scale_sel = 2'b00;
   logic [15:0] disp = '0;
   logic        ea_vld, upd_en;
   logic [31:0] ea, upd_val;

   int total = 0;
   int bad   = 0;

   typedef struct {
      logic [31:0] ea;
      logic        wb;
      logic [31:0] val;
      string       tag;
   } exp_t;

   exp_t sb[$];

   always #10 clk = ~clk;

   eff_addr_gen u_dut (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_mode(req_mode),
      .reg_ptr(reg_ptr), .reg_idx(reg_idx), .seg_base(seg_base),
      .opnd_size(opnd_size), .scale_sel(scale_sel), .disp(disp),
      .ea_vld(ea_vld), .ea(ea), .upd_en(upd_en), .upd_val(upd_val)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // Driver: compute expectation from the requirements, queue it, drive it.
   task automatic send(input logic [1:0] m, input logic [31:0] p, input logic [31:0] ix,
                       input logic [31:0] sg, input logic [1:0] sz, input logic [1:0] sc,
                       input logic [15:0] d, input string tag);
      exp_t e;
      logic [31:0] stepb, dext;
      stepb = 32'd1 << sz;                 // R5
      dext  = {{16{d[15]}}, d};            // R10
      e.tag = tag;
      e.val = '0;
      case (m)
         2'b00: begin e.ea = p; e.wb = 1'b0; end                        // R2
         2'b01: begin e.ea = p; e.wb = 1'b1; e.val = p + stepb; end     // R3
         2'b10: begin e.val = p - stepb; e.ea = e.val; e.wb = 1'b1; end // R4
         default: begin e.ea = sg + (ix << sc) + p + dext; e.wb = 1'b0; end // R6 R7
      endcase
      sb.push_back(e);
      @(negedge clk);
      req_vld = 1'b1; req_mode = m; reg_ptr = p; reg_idx = ix;
      seg_base = sg; opnd_size = sz; scale_sel = sc; disp = d;
   endtask

   task automatic idle_check(input int n);
      @(negedge clk);
      req_vld = 1'b0;
      reg_ptr = 32'hDEAD_BEEF;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         chk("R9 idle ea_vld", {31'b0, ea_vld}, 32'd0);
         chk("R9 idle upd_en", {31'b0, upd_en}, 32'd0);
      end
   endtask

   // Monitor: pop and compare on each valid result.
   always @(negedge clk) begin
      if (rst_n && ea_vld) begin
         if (sb.size() == 0) begin
            chk("R9 unexpected valid", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk({e.tag, " ea"}, ea, e.ea);
            chk({e.tag, " upd_en"}, {31'b0, upd_en}, {31'b0, e.wb});
            if (e.wb) chk({e.tag, " upd_val"}, upd_val, e.val);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL R9 watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: quiet during reset, even with a request pending on the inputs
      req_vld = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 ea_vld in reset", {31'b0, ea_vld}, 32'd0);
      chk("R1 upd_en in reset", {31'b0, upd_en}, 32'd0);
      req_vld = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ea_vld after reset", {31'b0, ea_vld}, 32'd0);
      chk("R1 upd_en after reset", {31'b0, upd_en}, 32'd0);

      // R2 indirect
      send(2'b00, 32'h0000_1000, 32'h55, 32'h77, 2'd2, 2'd1, 16'h10, "R2");
      // R3 / R5 post-increment across every size code
      for (int s = 0; s < 4; s++)
         send(2'b01, 32'h0000_2000 + s, 32'h0, 32'h0, 2'(s), 2'd0, 16'h0, "R3 R5 post");
      // R4 / R5 pre-decrement across every size code
      for (int s = 0; s < 4; s++)
         send(2'b10, 32'h0000_3000, 32'h0, 32'h0, 2'(s), 2'd0, 16'h0, "R4 R5 pre");
      idle_check(2);

      // R8 wrap cases
      send(2'b10, 32'h0000_0000, 32'h0, 32'h0, 2'd3, 2'd0, 16'h0, "R8 pre wrap");
      send(2'b01, 32'hFFFF_FFFF, 32'h0, 32'h0, 2'd2, 2'd0, 16'h0, "R8 post wrap");
      send(2'b11, 32'hF000_0000, 32'h2000_0000, 32'h1000_0000, 2'd0, 2'd3, 16'h0004, "R8 sum wrap");

      // R6 / R7 scaled index, every scale code
      for (int c = 0; c < 4; c++)
         send(2'b11, 32'h0000_0100, 32'h0000_0013, 32'h0001_0000, 2'd0, 2'(c), 16'h0020, "R6 R7 scaled");
      // R10 negative displacements
      send(2'b11, 32'h0000_0100, 32'h4, 32'h0002_0000, 2'd1, 2'd2, 16'hFFF0, "R10 neg disp");
      send(2'b11, 32'h0, 32'h0, 32'h0, 2'd0, 2'd0, 16'h8000, "R10 min disp");
      // R2 indirect ignores size, index, segment and displacement
      send(2'b00, 32'hABCD_0123, 32'hFFFF, 32'h1234, 2'd3, 2'd3, 16'hFFFF, "R2 ignore");
      idle_check(3);

      // R9 interleaved modes back to back
      send(2'b01, 32'h100, 32'h0, 32'h0, 2'd1, 2'd0, 16'h0, "R9 mix");
      send(2'b11, 32'h200, 32'h3, 32'h40, 2'd0, 2'd1, 16'h1, "R9 mix");
      send(2'b10, 32'h300, 32'h0, 32'h0, 2'd2, 2'd0, 16'h0, "R9 mix");
      send(2'b00, 32'h400, 32'h0, 32'h0, 2'd0, 2'd0, 16'h0, "R9 mix");
      idle_check(2);

      repeat (2) @(negedge clk);
      chk("R9 queue drained", 32'(sb.size()), 32'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule